// File: doc/BRIEF.md
# Adaptive Search Distance Tuner

This block chooses, frame by frame, the distance at which a motion search places its off-centre start points. It keeps a base distance and a probe step. Each probe round spans three frames: the first runs at the base distance, the second at the base plus the step, and the third at the base minus the step. Every trial is clamped to a legal range.

The surrounding search logic pulses a strobe when a frame begins and samples the distance output from the next cycle on. When the frame ends, it pulses a second strobe together with the total best-match cost it gathered for that frame. After the third frame of a round, the trial with the lowest cost becomes the new base and the step is halved. Once the step reaches one it stays there, so the base keeps moving by at most one per round. This continues until a restart pulse brings the tuner back to its initial values. Adapting the base takes no cycles of its own: a frame that starts in the same cycle that a round closes already receives the updated distance.

Top module: `search_dist_tuner`

## Requirements
- R1: After reset the distance output is 5, the probe step is 10 and the next frame is the first of a round.
- R2: On a cycle with `frame_start` high, `dist_out` takes the trial for the current frame of the round, visible from the next cycle. The first frame uses base, the second base+step and the third base−step. Without `frame_start`, `dist_out` holds its value.
- R3: Each `frame_end` pulse records `frame_cost` for the current frame of the round and advances to the next frame of the round; the third pulse closes the round.
- R4: When a round closes, the base becomes the trial of that round with the lowest cost. On equal costs the first-frame trial wins over the others, and the second-frame trial wins over the third.
- R5: When a round closes, the step is halved with integer division (10, 5, 2, 1); once it is 1 it stays 1.
- R6: Every trial distance is clamped to the range 0 to 64: base−step below 0 gives 0, and base+step above 64 gives 64.
- R7: A `restart` pulse sets base 5, step 10 and the first frame of a round. It overrides a `frame_end` in the same cycle, and a `frame_start` in the same cycle loads 5.
- R8: When `frame_end` and `frame_start` fall in the same cycle, the frame end is applied first and the new frame receives the trial of the updated state, including a base chosen by a round closing in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse: a frame begins, load its trial distance |
| frame_end | input | 1 | One-cycle pulse: a frame finished, `frame_cost` is valid |
| frame_cost | input | COST_W | Total best-match cost of the finished frame |
| restart | input | 1 | One-cycle pulse: return to the initial base and step |
| dist_out | output | DIST_W | Distance for the current frame's off-centre start points |

## Verification
The end of one frame and the start of the next can land in the same cycle, and so can a restart with either strobe. The bench provokes these in two ways. It runs directed rounds in which every frame end coincides with the following frame start, including the closing frame of a round, and it issues restarts alongside frame ends and frame starts. It also drives long stretches of random strobes with small costs, so that ties are frequent. A behavioural model applies end before start, with restart taking priority. The distance output is compared with this model on every clock, and fixed expected distances are checked after the directed cases.

// File: rtl/search_dist_tuner.sv
module search_dist_tuner #(
  parameter int DIST_W    = 7,
  parameter int COST_W    = 24,
  parameter int MAX_DIST  = 64,
  parameter int INIT_DIST = 5,
  parameter int INIT_STEP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic [COST_W-1:0] frame_cost,
  input  logic              restart,
  output logic [DIST_W-1:0] dist_out
);

  localparam int SUM_W = DIST_W + 1;
  localparam logic [DIST_W-1:0] D_MAX  = DIST_W'(MAX_DIST);
  localparam logic [DIST_W-1:0] D_INIT = DIST_W'(INIT_DIST);
  localparam logic [DIST_W-1:0] S_INIT = DIST_W'(INIT_STEP);

  logic [DIST_W-1:0] base_q, step_q, base_n, step_n;
  logic [1:0]        phase_q, phase_n;
  logic [COST_W-1:0] cost0_q, cost1_q;
  logic              last_frame;

  function automatic logic [DIST_W-1:0] trial(input logic [DIST_W-1:0] b,
                                              input logic [DIST_W-1:0] s,
                                              input logic [1:0]        p);
    logic [SUM_W-1:0] up;
    up = {1'b0, b} + {1'b0, s};
    case (p)
      2'd1:    trial = (up > {1'b0, D_MAX}) ? D_MAX : up[DIST_W-1:0];
      2'd2:    trial = (b > s) ? b - s : '0;
      default: trial = b;
    endcase
  endfunction

  assign last_frame = (phase_q == 2'd2);

  logic [1:0] win;
  always_comb begin
    if (cost0_q <= cost1_q && cost0_q <= frame_cost) win = 2'd0;
    else if (cost1_q <= frame_cost)                  win = 2'd1;
    else                                             win = 2'd2;
  end

  always_comb begin
    base_n  = base_q;
    step_n  = step_q;
    phase_n = phase_q;
    if (restart) begin
      base_n  = D_INIT;
      step_n  = S_INIT;
      phase_n = 2'd0;
    end else if (frame_end) begin
      if (last_frame) begin
        base_n  = trial(base_q, step_q, win);
        step_n  = (step_q > DIST_W'(1)) ? (step_q >> 1) : DIST_W'(1);
        phase_n = 2'd0;
      end else begin
        phase_n = phase_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= D_INIT;
      step_q   <= S_INIT;
      phase_q  <= 2'd0;
      cost0_q  <= '0;
      cost1_q  <= '0;
      dist_out <= D_INIT;
    end else begin
      base_q  <= base_n;
      step_q  <= step_n;
      phase_q <= phase_n;
      if (frame_end && !restart && phase_q == 2'd0) cost0_q <= frame_cost;
      if (frame_end && !restart && phase_q == 2'd1) cost1_q <= frame_cost;
      if (frame_start) dist_out <= trial(base_n, step_n, phase_n);
    end
  end

endmodule

module search_dist_tuner_chk #(
  parameter int DIST_W    = 7,
  parameter int MAX_DIST  = 64,
  parameter int INIT_DIST = 5,
  parameter int INIT_STEP = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              frame_end,
  input logic              restart,
  input logic [DIST_W-1:0] dist_out,
  input logic [DIST_W-1:0] step_q,
  input logic [1:0]        phase_q
);

  AST_DIST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dist_out <= DIST_W'(MAX_DIST)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(dist_out)); // R2
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && frame_start) |=> dist_out == DIST_W'(INIT_DIST)); // R7
  AST_RESTART_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (step_q == DIST_W'(INIT_STEP) && phase_q == 2'd0)); // R7
  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !restart && phase_q != 2'd2) |=> phase_q == 2'($past(phase_q) + 2'd1)); // R3
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3); // R3
  AST_STEP_HALVE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !restart && phase_q == 2'd2 && step_q > DIST_W'(1)) |=> step_q == ($past(step_q) >> 1)); // R5
  AST_STEP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != '0); // R5

endmodule

bind search_dist_tuner search_dist_tuner_chk #(
  .DIST_W(DIST_W), .MAX_DIST(MAX_DIST), .INIT_DIST(INIT_DIST), .INIT_STEP(INIT_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
  .restart(restart), .dist_out(dist_out), .step_q(step_q), .phase_q(phase_q)
);

// File: tb/test_search_dist_tuner.sv
module test_search_dist_tuner;
  localparam int DIST_W = 7;
  localparam int COST_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, frame_end = 1'b0, restart = 1'b0;
  logic [COST_W-1:0] frame_cost = '0;
  logic [DIST_W-1:0] dist_out;

  always #10 clk = ~clk;

  search_dist_tuner i_search_dist_tuner (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .frame_cost(frame_cost), .restart(restart), .dist_out(dist_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_base = 5, m_step = 10, m_phase = 0, m_dist = 5;
  int m_cost[3];

  function automatic int m_trial(int p);
    if (p == 1) return (m_base + m_step > 64) ? 64 : m_base + m_step;
    if (p == 2) return (m_base - m_step < 0) ? 0 : m_base - m_step;
    return m_base;
  endfunction

  task automatic model(bit fs, bit fe, bit rs, int cost);
    if (rs) begin
      m_base = 5; m_step = 10; m_phase = 0;
    end else if (fe) begin
      m_cost[m_phase] = cost;
      if (m_phase < 2) m_phase++;
      else begin
        int best = 0;
        for (int k = 1; k < 3; k++) if (m_cost[k] < m_cost[best]) best = k;
        m_base = m_trial(best);
        m_step = (m_step > 1) ? m_step / 2 : 1;
        m_phase = 0;
      end
    end
    if (fs) m_dist = m_trial(m_phase);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s dist_out actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit fs, bit fe, bit rs, int cost, string tag);
    frame_start = fs; frame_end = fe; restart = rs; frame_cost = COST_W'(cost);
    model(fs, fe, rs, cost);
    @(negedge clk);
    check(int'(dist_out) == m_dist, tag, int'(dist_out), m_dist);
  endtask

  task automatic expect_dist(int exp, string tag);
    check(int'(dist_out) == exp, tag, int'(dist_out), exp);
  endtask

  task automatic frame(int cost, int exp, string tag);
    cyc(1, 0, 0, 0, tag);
    if (exp >= 0) expect_dist(exp, tag);
    cyc(0, 0, 0, 0, tag);
    cyc(0, 1, 0, cost, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_dist(5, "R1");
    // round 1: trials 5, 15, 0 (clamped); second frame cheapest
    frame(100, 5, "R2");
    frame(50, 15, "R2");
    cyc(1, 0, 0, 0, "R6"); expect_dist(0, "R6");
    cyc(0, 0, 0, 0, "R6");
    // round closes while next frame starts: base 15, step 5
    cyc(1, 1, 0, 80, "R8"); expect_dist(15, "R8");
    cyc(0, 0, 0, 0, "R8");
    cyc(1, 1, 0, 30, "R8"); expect_dist(20, "R5");
    cyc(0, 0, 0, 0, "R8");
    cyc(1, 1, 0, 30, "R8"); expect_dist(10, "R2");
    cyc(0, 0, 0, 0, "R8");
    // all equal: first-frame trial keeps base 15, step 2
    cyc(1, 1, 0, 30, "R4"); expect_dist(15, "R4");
    cyc(0, 0, 0, 0, "R4");
    cyc(0, 1, 0, 40, "R4");
    frame(20, 17, "R5");
    frame(20, 13, "R5");
    // tie between second and third: base 17, step 1
    frame(9, 17, "R4");
    frame(9, 18, "R5");
    frame(1, 16, "R5");
    frame(5, 16, "R4");
    frame(5, 17, "R5");
    frame(5, 15, "R5");
    // restart together with a frame end
    cyc(1, 0, 0, 0, "R7"); expect_dist(16, "R7");
    cyc(0, 0, 0, 0, "R7");
    cyc(0, 1, 1, 3, "R7");
    frame(7, 5, "R7");
    // restart together with a frame start
    cyc(1, 0, 1, 0, "R7"); expect_dist(5, "R7");
    cyc(0, 0, 0, 0, "R7");
    cyc(0, 1, 0, 100, "R3");
    frame(50, 15, "R3");
    frame(200, 0, "R6");
    // climb to the upper clamp
    for (int r = 0; r < 50; r++) begin
      frame(10, -1, "R6");
      frame(1, -1, "R6");
      frame(10, -1, "R6");
    end
    frame(10, 64, "R6");
    frame(10, 64, "R6");
    frame(10, 63, "R6");
    // random strobes with frequent ties and coincidences
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 80) == 0,
          int'($urandom % 8), "R8");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule